// File: doc/BRIEF.md
# Quad select-gated transparent latch

Four identical bit slices share one pair of select lines, two active-low enables and one master reset. In each slice the select code gates the two data inputs separately: one code passes the first input, one passes the second, one ORs them together, and one forces the slice input low. The gated value then goes to a level-sensitive latch with a true output and a complementary output.

The latches follow their gated input only while both enables are low. Raising either enable freezes every slice at the value it held just before. The master reset overrides everything else: it clears the true outputs and sets the complementary outputs, whether the latch is open or holding. The block has no clock. It is plain level-sensitive storage and is meant to sit where a small registered selector would add a cycle of latency.

Top module: `quad_gate_latch`

## Requirements
- R1: With sel1=0 and sel0=0 and the latch open, each bit of q equals the matching bit of din0.
- R2: With sel1=1 and sel0=1 and the latch open, each bit of q equals the matching bit of din1.
- R3: With sel1=1 and sel0=0 and the latch open, each bit of q is the OR of the matching din0 and din1 bits.
- R4: With sel1=0 and sel0=1 and the latch open, q is all zeros whatever the data inputs are.
- R5: The latch is open only while en1_n and en2_n are both low. While it is open, q follows the gated input with no clock.
- R6: Once either enable is high, q keeps the value it had just before. Later changes on din0, din1, sel0 or sel1 leave q unchanged until both enables are low again.
- R7: While rst is high, q is all zeros and q_n is all ones, whatever the enables, selects and data are.
- R8: If rst falls while the latch is holding, q stays all zeros until both enables are low. Then q takes the gated input.
- R9: q_n is the bitwise inverse of q at all times, including during reset and while holding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Master reset, active high, overrides all other inputs |
| en1_n | input | 1 | First enable, active low |
| en2_n | input | 1 | Second enable, active low |
| sel0 | input | 1 | Select bit 0 (high blocks din0) |
| sel1 | input | 1 | Select bit 1 (high admits din1) |
| din0 | input | W | First data source, one bit per slice |
| din1 | input | W | Second data source, one bit per slice |
| q | output | W | True latch outputs |
| q_n | output | W | Complementary latch outputs |

## Verification
No register lies between any input and the outputs. Every result is therefore due in the same time step as the stimulus that causes it: zero clock cycles for transparent data, for reset and for the enable edges. The bench uses its clock only for pacing. It changes inputs on the falling edge and samples one nanosecond later, so every level has settled and no check depends on the order of processes at an edge. For the hold cases, the bench first raises an enable and samples. It then disturbs the data and select inputs and samples again before lowering the enable.

// File: rtl/quad_gate_latch.sv
module quad_gate_latch #(
  parameter int W = 4
) (
  input  logic         rst,
  input  logic         en1_n,
  input  logic         en2_n,
  input  logic         sel0,
  input  logic         sel1,
  input  logic [W-1:0] din0,
  input  logic [W-1:0] din1,
  output logic [W-1:0] q,
  output logic [W-1:0] q_n
);

  logic         open_w;
  logic [W-1:0] mix;

  assign open_w = ~en1_n & ~en2_n;
  assign mix    = (din0 & {W{~sel0}}) | (din1 & {W{sel1}});

  always_latch begin
    if (rst) begin
      q   <= '0;
      q_n <= '1;
    end else if (open_w) begin
      q   <= mix;
      q_n <= ~mix;
    end
  end

endmodule

module quad_gate_latch_chk #(
  parameter int W = 4
) (
  input logic         rst,
  input logic         en1_n,
  input logic         en2_n,
  input logic         sel0,
  input logic         sel1,
  input logic [W-1:0] din0,
  input logic [W-1:0] din1,
  input logic [W-1:0] q,
  input logic [W-1:0] q_n
);

  logic known;
  logic live;

  assign known = !$isunknown({rst, en1_n, en2_n, sel0, sel1, din0, din1});
  assign live  = known && !rst && !en1_n && !en2_n;

  always_comb begin
    if (known && rst) begin
      p_reset_clear_r7: assert (q == '0 && q_n == '1);
    end
    if (known) begin
      p_comp_inverse_r9: assert (q_n == ~q);
    end
    if (live && !sel1 && !sel0) begin
      p_pass_first_r1: assert (q == din0);
    end
    if (live && sel1 && sel0) begin
      p_pass_second_r2: assert (q == din1);
    end
    if (live && sel1 && !sel0) begin
      p_or_both_r3: assert (q == (din0 | din1));
    end
    if (live && !sel1 && sel0) begin
      p_force_low_r4: assert (q == '0);
    end
  end

endmodule

bind quad_gate_latch quad_gate_latch_chk #(.W(W)) u_chk (
  .rst(rst), .en1_n(en1_n), .en2_n(en2_n), .sel0(sel0), .sel1(sel1),
  .din0(din0), .din1(din1), .q(q), .q_n(q_n)
);

// File: tb/sim_quad_gate_latch.sv
`timescale 1ns/1ps
module sim_quad_gate_latch;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst, en1_n, en2_n, sel0, sel1;
  logic [W-1:0] din0, din1, q, q_n;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  quad_gate_latch #(.W(W)) u0 (
    .rst(rst), .en1_n(en1_n), .en2_n(en2_n), .sel0(sel0), .sel1(sel1),
    .din0(din0), .din1(din1), .q(q), .q_n(q_n)
  );

  function automatic logic [W-1:0] gated(input logic s1, input logic s0,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    r = '0;
    if (!s0) r = r | a;
    if (s1)  r = r | b;
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp);
    end
    n_chk++;
    if (q_n !== ~exp) begin
      n_bad++;
      $display("FAIL R9 (%s): q_n=%h expected %h", tag, q_n, ~exp);
    end
  endtask

  task automatic drive(input logic r, input logic e1, input logic e2, input logic s1,
                       input logic s0, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    rst = r; en1_n = e1; en2_n = e2; sel1 = s1; sel0 = s0; din0 = a; din1 = b;
    #1;
  endtask

  initial begin
    rst = 1'b1; en1_n = 1'b0; en2_n = 1'b0; sel0 = 1'b0; sel1 = 1'b0;
    din0 = '0; din1 = '0;

    drive(1, 0, 0, 1, 1, 4'hF, 4'hF);
    check("R7 reset over open latch", 4'h0);
    drive(0, 0, 0, 1, 1, 4'hF, 4'hF);
    check("R5 open after reset", 4'hF);

    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          drive(0, 0, 0, s[1], s[0], a[W-1:0], b[W-1:0]);
          case (s)
            0: check("R1 pass din0", gated(0, 0, a[W-1:0], b[W-1:0]));
            1: check("R4 force low", gated(0, 1, a[W-1:0], b[W-1:0]));
            2: check("R3 or of both", gated(1, 0, a[W-1:0], b[W-1:0]));
            default: check("R2 pass din1", gated(1, 1, a[W-1:0], b[W-1:0]));
          endcase
        end
      end
    end

    drive(0, 0, 0, 1, 1, 4'h3, 4'hA);
    check("R2 preload", 4'hA);
    drive(0, 1, 0, 1, 1, 4'h3, 4'hA);
    check("R6 en1 raised", 4'hA);
    drive(0, 1, 0, 0, 0, 4'h5, 4'h6);
    check("R6 en1 hold ignores inputs", 4'hA);
    drive(0, 1, 0, 1, 0, 4'hF, 4'hF);
    check("R6 en1 hold ignores select", 4'hA);
    drive(0, 0, 0, 0, 0, 4'h5, 4'h6);
    check("R5 reopen after en1", 4'h5);

    drive(0, 0, 1, 0, 0, 4'h5, 4'h6);
    check("R6 en2 raised", 4'h5);
    drive(0, 0, 1, 1, 1, 4'h0, 4'h9);
    check("R6 en2 hold ignores inputs", 4'h5);
    drive(0, 0, 0, 1, 1, 4'h0, 4'h9);
    check("R5 reopen after en2", 4'h9);

    drive(0, 1, 1, 1, 1, 4'h0, 4'h9);
    check("R6 both raised", 4'h9);
    drive(0, 1, 1, 0, 1, 4'hF, 4'h0);
    check("R6 both hold ignores force", 4'h9);
    drive(0, 0, 1, 0, 1, 4'hF, 4'h0);
    check("R5 one enable still high", 4'h9);
    drive(0, 0, 0, 0, 1, 4'hF, 4'h0);
    check("R4 reopen forced low", 4'h0);

    drive(0, 0, 0, 1, 0, 4'hC, 4'h3);
    check("R3 preload", 4'hF);
    drive(0, 0, 1, 1, 0, 4'hC, 4'h3);
    check("R6 hold before reset", 4'hF);
    drive(1, 0, 1, 1, 0, 4'hC, 4'h3);
    check("R7 reset while holding", 4'h0);
    drive(0, 0, 1, 1, 0, 4'hC, 4'h3);
    check("R8 release while holding", 4'h0);
    drive(0, 0, 1, 1, 1, 4'hF, 4'hF);
    check("R8 still cleared", 4'h0);
    drive(0, 0, 0, 1, 1, 4'hF, 4'h7);
    check("R8 reopen takes input", 4'h7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule